// File: doc/BRIEF.md
# Asynchronous SRAM Host Bridge

This block connects a synchronous host to an external asynchronous static RAM of 262,144 bytes. The host issues one-clock requests: a valid strobe, a write flag, an 18-bit word address and a data byte for writes. The bridge turns each accepted request into one memory access and holds it for a fixed number of clocks, so that the memory's 70 ns access and cycle time is met. On a read it returns the byte with a one-clock strobe.

The memory is selected through a pair of chip selects of opposite polarity: one active low and one active high. It also has an active-low write strobe, an active-low output enable, an address bus and a shared 8-bit data bus. Between accesses the bridge deselects the memory, so the part falls back to its standby state. The bridge drives the data bus only while a write is in progress. When the direction of transfer changes, it adds one dead clock so that the two drivers never overlap.

The hold length is worked out when the block is built. The clock period and the memory cycle time are both given in picoseconds, and their rounded-up ratio sets the length, with a floor of three clocks.

Top module: `sram_host_bridge`

## Requirements
- R1: When no access is in progress, the memory is deselected and all strobes are inactive: mem_sel_n=1, mem_sel=0, mem_we_n=1, mem_oe_n=1.
- R2: req_ready is 1 only while the bridge is idle. A request is taken only on a clock where req_valid and req_ready are both 1. A request raised while req_ready=0 starts no access and does not change the access already running.
- R3: Every access keeps the memory selected (mem_sel_n=0, mem_sel=1) for exactly CYCLE_CLKS consecutive clocks. CYCLE_CLKS = max(3, ceil(ACCESS_PS / CLK_PS)), which is 9 with the default values 70000 and 8000.
- R4: A write keeps mem_oe_n=1 for the whole access. It drives mem_we_n=0 on every selected clock except the first and the last, so the write strobe is low for CYCLE_CLKS-2 clocks.
- R5: A read drives mem_oe_n=0 and mem_we_n=1 on every selected clock.
- R6: mem_addr equals the accepted req_addr for the whole access. It never changes while mem_we_n=0.
- R7: The bridge drives mem_dq only during a write access, and the value it drives is the req_wdata captured when the request was taken. Later changes to req_wdata or req_addr have no effect.
- R8: If an access is in the opposite direction to the one before it, one extra clock is inserted with the memory deselected and all strobes inactive. Consecutive accesses in the same direction get no extra clock.
- R9: After a read, rd_valid is 1 for exactly one clock, in the first idle clock. In that clock rd_data holds the byte on mem_dq during the last selected clock of the read.
- R10: A read returns the byte most recently written to the same address.
- R11: After reset the bridge is idle with req_ready=1 and rd_valid=0, and the memory is deselected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Host request strobe |
| req_write | input | 1 | 1 for write, 0 for read |
| req_addr | input | 18 | Word address |
| req_wdata | input | 8 | Write byte |
| req_ready | output | 1 | Bridge idle, request can be taken |
| rd_valid | output | 1 | One-clock read-return strobe |
| rd_data | output | 8 | Read byte |
| mem_sel_n | output | 1 | Active-low chip select |
| mem_sel | output | 1 | Active-high chip select |
| mem_we_n | output | 1 | Active-low write strobe |
| mem_oe_n | output | 1 | Active-low output enable |
| mem_addr | output | 18 | Memory address bus |
| mem_dq | inout | 8 | Shared memory data bus |

## Verification
The bench builds the bridge with its default values: an 8000 ps clock and a 70000 ps cycle time. This gives a nine-clock access with a seven-clock write strobe, so the strobe window is well away from both ends of the access. The accesses use the lowest and highest addresses, runs of the same direction and alternating directions. This brings both the turnaround path and the direct path within reach. One request is also raised in the middle of a busy access and must be ignored.

// File: rtl/sram_bridge_pkg.sv
package sram_bridge_pkg;

  typedef enum logic [1:0] {
    BR_IDLE  = 2'd0,
    BR_TURN  = 2'd1,
    BR_READ  = 2'd2,
    BR_WRITE = 2'd3
  } bridge_state_e;

  // Clocks to hold one access: rounded-up ratio, never below three.
  function automatic int hold_clocks(input int access_ps, input int clk_ps);
    int n;
    n = (access_ps + clk_ps - 1) / clk_ps;
    return (n < 3) ? 3 : n;
  endfunction

  // Write strobe window: all access clocks but the first and the last.
  function automatic logic strobe_window(input int idx, input int n);
    return (idx != 0) && (idx != n - 1);
  endfunction

  // A turnaround is needed when a previous access exists and differs in direction.
  function automatic logic needs_turn(input logic seen, input logic prev_wr, input logic next_wr);
    return seen && (prev_wr != next_wr);
  endfunction

endpackage

// File: rtl/sram_cycle_timer.sv
module sram_cycle_timer #(
  parameter int CYCLE_CLKS = 9,
  localparam int CNT_W = $clog2(CYCLE_CLKS + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             active,
  output logic [CNT_W-1:0] idx,
  output logic             last
);

  localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(CYCLE_CLKS - 1);

  assign last = active && (idx == LAST_IDX);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      idx <= '0;
    else if (active && !last)
      idx <= idx + 1'b1;
    else
      idx <= '0;
  end

endmodule

// File: rtl/sram_seq_fsm.sv
module sram_seq_fsm
  import sram_bridge_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic          req_write,
  input  logic          last,
  output bridge_state_e state,
  output logic          accept,
  output logic          ready
);

  bridge_state_e nxt;
  logic op_wr, prev_wr, seen;

  assign ready  = (state == BR_IDLE);
  assign accept = ready && req_valid;

  always_comb begin
    nxt = state;
    unique case (state)
      BR_IDLE:
        if (accept) begin
          if (needs_turn(seen, prev_wr, req_write)) nxt = BR_TURN;
          else nxt = req_write ? BR_WRITE : BR_READ;
        end
      BR_TURN:  nxt = op_wr ? BR_WRITE : BR_READ;
      BR_READ:  if (last) nxt = BR_IDLE;
      BR_WRITE: if (last) nxt = BR_IDLE;
      default:  nxt = BR_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= BR_IDLE;
      op_wr   <= 1'b0;
      prev_wr <= 1'b0;
      seen    <= 1'b0;
    end else begin
      state <= nxt;
      if (accept) begin
        op_wr   <= req_write;
        prev_wr <= req_write;
        seen    <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/sram_data_path.sv
module sram_data_path #(
  parameter int ADDR_W = 18,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic              capture,
  input  logic [DATA_W-1:0] bus_in,
  output logic [ADDR_W-1:0] addr_q,
  output logic [DATA_W-1:0] wdata_q,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q  <= '0;
      wdata_q <= '0;
    end else if (accept) begin
      addr_q  <= req_addr;
      wdata_q <= req_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= capture;
      if (capture) rd_data <= bus_in;
    end
  end

endmodule

// File: rtl/sram_host_bridge.sv
module sram_host_bridge
  import sram_bridge_pkg::*;
#(
  parameter int ADDR_W    = 18,
  parameter int DATA_W    = 8,
  parameter int CLK_PS    = 8000,
  parameter int ACCESS_PS = 70000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              req_ready,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data,
  output logic              mem_sel_n,
  output logic              mem_sel,
  output logic              mem_we_n,
  output logic              mem_oe_n,
  output logic [ADDR_W-1:0] mem_addr,
  inout  wire  [DATA_W-1:0] mem_dq
);

  localparam int CYCLE_CLKS = hold_clocks(ACCESS_PS, CLK_PS);
  localparam int CNT_W      = $clog2(CYCLE_CLKS + 1);

  bridge_state_e     state;
  logic              accept, last, in_access, capture, drv_en;
  logic [CNT_W-1:0]  idx;
  logic [DATA_W-1:0] wdata_q;

  assign in_access = (state == BR_READ) || (state == BR_WRITE);
  assign capture   = (state == BR_READ) && last;
  assign drv_en    = (state == BR_WRITE);

  sram_seq_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .last(last), .state(state), .accept(accept), .ready(req_ready)
  );

  sram_cycle_timer #(.CYCLE_CLKS(CYCLE_CLKS)) u_timer (
    .clk(clk), .rst_n(rst_n), .active(in_access), .idx(idx), .last(last)
  );

  sram_data_path #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_data (
    .clk(clk), .rst_n(rst_n), .accept(accept), .req_addr(req_addr),
    .req_wdata(req_wdata), .capture(capture), .bus_in(mem_dq),
    .addr_q(mem_addr), .wdata_q(wdata_q), .rd_valid(rd_valid), .rd_data(rd_data)
  );

  assign mem_sel_n = !in_access;
  assign mem_sel   = in_access;
  assign mem_oe_n  = !(state == BR_READ);
  assign mem_we_n  = !(drv_en && strobe_window(int'(idx), CYCLE_CLKS));
  assign mem_dq    = drv_en ? wdata_q : {DATA_W{1'bz}};

endmodule

// File: rtl/sram_bridge_checker.sv
module sram_bridge_checker #(
  parameter int ADDR_W     = 18,
  parameter int CYCLE_CLKS = 9
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_ready,
  input logic              accept,
  input logic              drv_en,
  input logic              rd_valid,
  input logic              mem_sel_n,
  input logic              mem_sel,
  input logic              mem_we_n,
  input logic              mem_oe_n,
  input logic [ADDR_W-1:0] mem_addr
);

  int run;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) run <= 0;
    else if (!mem_sel_n) run <= run + 1;
    else run <= 0;
  end

  AST_IDLE_DESELECT: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (mem_sel_n && !mem_sel && mem_we_n && mem_oe_n)); // R1
  AST_ACCEPT_READY: assert property (@(posedge clk) disable iff (!rst_n)
    accept |-> req_ready); // R2
  AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_sel_n |-> !req_ready); // R2
  AST_HOLD_LENGTH: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_sel_n && !$past(mem_sel_n)) |-> (run == CYCLE_CLKS)); // R3
  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(!mem_we_n && !mem_oe_n)); // R4
  AST_STROBE_INSIDE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mem_we_n) |-> $past(!mem_sel_n)); // R4
  AST_ADDR_UNDER_WE: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_we_n && !$past(mem_we_n)) |-> $stable(mem_addr)); // R6
  AST_DRIVE_WRITE_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    drv_en |-> (!mem_sel_n && mem_oe_n)); // R7
  AST_RDVALID_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |=> !rd_valid); // R9

endmodule

bind sram_host_bridge sram_bridge_checker #(.ADDR_W(ADDR_W), .CYCLE_CLKS(CYCLE_CLKS)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_ready(req_ready), .accept(accept), .drv_en(drv_en),
  .rd_valid(rd_valid), .mem_sel_n(mem_sel_n), .mem_sel(mem_sel), .mem_we_n(mem_we_n),
  .mem_oe_n(mem_oe_n), .mem_addr(mem_addr)
);

// File: tb/tb_sram_host_bridge.sv
module tb_sram_host_bridge;

  localparam int CLK_PS = 8000;
  localparam int ACC_PS = 70000;
  localparam int N = ((ACC_PS + CLK_PS - 1) / CLK_PS < 3) ? 3 : (ACC_PS + CLK_PS - 1) / CLK_PS;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [17:0] req_addr = '0;
  logic [7:0]  req_wdata = '0;
  logic req_ready, rd_valid, mem_sel_n, mem_sel, mem_we_n, mem_oe_n;
  logic [7:0]  rd_data;
  logic [17:0] mem_addr;
  wire  [7:0]  mem_dq;

  int checks = 0, errors = 0;
  bit have_last = 0, last_wr = 0;
  logic [7:0] ref_mem [int];
  logic [7:0] mdl_mem [int];
  logic [7:0] mdl_q = '0;
  logic mdl_en;

  always #4ns clk = ~clk;

  sram_host_bridge dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_ready(req_ready),
    .rd_valid(rd_valid), .rd_data(rd_data), .mem_sel_n(mem_sel_n), .mem_sel(mem_sel),
    .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n), .mem_addr(mem_addr), .mem_dq(mem_dq)
  );

  // Behavioural asynchronous memory
  function automatic logic [7:0] fill(input logic [17:0] a);
    return a[7:0] ^ 8'h5A;
  endfunction

  assign mdl_en = !mem_sel_n && mem_sel && !mem_oe_n && mem_we_n;
  assign mem_dq = mdl_en ? mdl_q : 8'hzz;

  always @(negedge clk) begin
    mdl_q <= mdl_mem.exists(int'(mem_addr)) ? mdl_mem[int'(mem_addr)] : fill(mem_addr);
    if (!mem_sel_n && mem_sel && !mem_we_n) mdl_mem[int'(mem_addr)] = mem_dq;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic chk_idle(input string req);
    chk(mem_sel_n && !mem_sel && mem_we_n && mem_oe_n, req,
        {mem_sel_n, mem_sel, mem_we_n, mem_oe_n}, 4'b1011);
  endtask

  task automatic access(input bit wr, input logic [17:0] a, input logic [7:0] d, input bit poke);
    bit turn;
    logic [7:0] exp;
    int guard = 0;
    while (!req_ready && guard < 100) begin @(negedge clk); guard++; end
    turn = have_last && (last_wr != wr);
    exp  = ref_mem.exists(int'(a)) ? ref_mem[int'(a)] : fill(a);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0; req_addr = ~a; req_wdata = ~d;
    if (turn) begin
      chk_idle("R8");
      chk(!req_ready, "R2", req_ready, 0);
      @(negedge clk);
    end
    for (int k = 0; k < N; k++) begin
      chk(!mem_sel_n && mem_sel, "R3", {mem_sel_n, mem_sel}, 2'b01);
      chk(mem_addr == a, "R6", mem_addr, a);
      chk(mem_oe_n == wr, wr ? "R4" : "R5", mem_oe_n, wr);
      chk(mem_we_n == !(wr && k != 0 && k != N - 1), wr ? "R4" : "R5",
          mem_we_n, !(wr && k != 0 && k != N - 1));
      chk(!req_ready, "R2", req_ready, 0);
      chk(!rd_valid, "R9", rd_valid, 0);
      if (wr) chk(mem_dq == d, "R7", mem_dq, d);
      if (poke && k == 2) begin req_valid = 1'b1; req_write = !wr; req_addr = a ^ 18'h1; end
      if (poke && k == 3) req_valid = 1'b0;
      @(negedge clk);
    end
    chk(req_ready, "R2", req_ready, 1);
    chk_idle("R1");
    if (wr) chk(!rd_valid, "R9", rd_valid, 0);
    else begin
      chk(rd_valid, "R9", rd_valid, 1);
      chk(rd_data == exp, "R10", rd_data, exp);
    end
    if (wr) ref_mem[int'(a)] = d;
    have_last = 1'b1;
    last_wr   = wr;
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    #(8ns * 200000);
    checks++; errors++;
    $display("FAIL watchdog: actual running expected done");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R11 reset state
    chk(req_ready && !rd_valid, "R11", {req_ready, rd_valid}, 2'b10);
    chk_idle("R11");

    access(1'b1, 18'h00000, 8'h3C, 1'b0);
    access(1'b1, 18'h3FFFF, 8'hC3, 1'b0);   // same direction, no turn R8
    access(1'b0, 18'h3FFFF, 8'h00, 1'b0);   // turn, R10
    access(1'b0, 18'h00000, 8'h00, 1'b0);
    access(1'b0, 18'h12345, 8'h00, 1'b0);   // unwritten location
    access(1'b1, 18'h12345, 8'hA7, 1'b1);   // request raised while busy, R2
    for (int i = 0; i < 5; i++) begin      // ignored request starts nothing
      @(negedge clk);
      chk(req_ready, "R2", req_ready, 1);
      chk_idle("R2");
    end
    access(1'b0, 18'h12345, 8'h00, 1'b0);
    access(1'b0, 18'h12344, 8'h00, 1'b0);   // poked address untouched, R7
    for (int i = 0; i < 6; i++) begin
      logic [17:0] a;
      a = 18'h0AB00 + 18'(i * 37);
      access(1'b1, a, 8'(i * 29 + 7), 1'b0);
      access(1'b0, a, 8'h00, 1'b0);
    end
    @(negedge clk);
    chk(!rd_valid, "R9", rd_valid, 0);
    finish_run();
  end

endmodule